// File: doc/BRIEF.md
# Text-Mode Character Pixel Serializer

This block turns a line of character codes into a stream of monochrome pixels for a text display. A CRT-controller-style timing unit supplies the start address of the current character row, the raster line inside that row and a line-start strobe. For each character column the block reads a code byte from video RAM and uses it to look up an 8-bit glyph slice in a character ROM. It then shifts that slice out as a 9-pixel cell, one pixel per clock.

Both memories sit outside the block and are synchronous, with one clock of read latency. The block drives their addresses and takes their data back. Fetches are pipelined so that each glyph slice is ready at the first pixel of its cell. The final pixel polarity combines three inversion sources: bit 7 of the character code, bit 13 of the row address and a cursor column match. A graphics-mode input controls the ninth pixel of each cell, and a display-enable input blanks the output.

Top module: `txt_pix_serializer`

## Requirements
- R1: The character ROM address is 12 bits: raster row in bits 3..0, character code bits 6..0 in bits 10..4, and the graphics-mode bit in bit 11. Row-address bit 12 falls outside this 12-bit window and has no effect on the glyph.
- R2: The code for column c is read from video RAM index (ma_i + c) modulo 2048, so the index wraps inside an 11-bit window.
- R3: A line-start strobe sampled at clock edge E0 makes the first pixel of column 0 visible in the cycle after edge E0+9. Each column lasts 9 cycles, and glyph bits come out most significant bit first.
- R4: Before cursor inversion, each pixel equals the glyph bit XOR code bit 7 XOR ma_i bit 13.
- R5: Every pixel of the cell whose column equals cursor_col_i is inverted, including the ninth pixel. A cursor value of chars_per_line_i or above marks no cell.
- R6: The ninth pixel of a cell, before inversion, is glyph bit 0 when gfx_mode_i is 1 and 0 when gfx_mode_i is 0.
- R7: When disp_en_i is low, pix_o is 0 in that same cycle.
- R8: A line-start strobe restarts the line from column 0 and blanks the output until the new first cell, even when the previous line is still running.
- R9: A line shows exactly chars_per_line_i cells (0 to 128). After the last cell, pix_o stays 0 until the next line start.
- R10: After reset, pix_o is 0 until a line is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_start_i | input | 1 | One-cycle strobe that starts a new line |
| disp_en_i | input | 1 | Display enable; output is blank while low |
| gfx_mode_i | input | 1 | Graphics-mode select (ROM bank bit and ninth-pixel fill) |
| ma_i | input | 14 | Row start address from the timing unit |
| ra_i | input | 4 | Raster line within the character row |
| chars_per_line_i | input | 8 | Number of cells in the line, 0 to 128 |
| cursor_col_i | input | 8 | Column whose cell is inverted |
| vram_addr_o | output | 11 | Video RAM read address |
| vram_data_i | input | 8 | Video RAM read data, one cycle after the address |
| crom_addr_o | output | 12 | Character ROM read address |
| crom_data_i | input | 8 | Character ROM read data, one cycle after the address |
| pix_o | output | 1 | Serial pixel |

## Verification
Lines are run with graphics mode off and on, and the fill values of the ninth pixel separate a repeated last bit from a blank one. Row addresses are chosen with bit 13 set to test page inversion, with bit 12 set to show that bit 12 leaves the glyph unchanged, and near the top of the 2 KB window to expose a missing index wrap. A cursor column inside the line, a toggling enable, a restart in the middle of a line, and widths of 1 and 128 columns with blank tails check the edges of the cell sequencing. The bench memories hold computed, non-repeating contents, so a wrong address or an off-by-one column produces wrong pixels.

// File: rtl/txt_pix_pkg.sv
`timescale 1ns/1ps
package txt_pix_pkg;
  localparam int CELL_PX   = 9;
  localparam int PX_W      = 4;
  localparam int GLYPH_W   = 8;
  localparam int FETCH_PX  = 1;  // phase where the code byte arrives
  localparam int PAT_PX    = 3;  // phase where the glyph byte arrives

  typedef struct packed {
    logic [GLYPH_W-1:0] pat;
    logic               rev;
    logic               page;
    logic               cur;
    logic               gfx;
    logic               valid;
  } cell_t;
endpackage

// File: rtl/tps_fetch.sv
`timescale 1ns/1ps
module tps_fetch
  import txt_pix_pkg::*;
#(
  parameter int MA_W     = 14,
  parameter int RA_W     = 4,
  parameter int VRAM_AW  = 11,
  parameter int COL_W    = 8,
  parameter int MAX_COLS = 128,
  localparam int CROM_AW = 1 + 7 + RA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               line_start_i,
  input  logic               gfx_i,
  input  logic [MA_W-1:0]    ma_i,
  input  logic [RA_W-1:0]    ra_i,
  input  logic [COL_W-1:0]   cpl_i,
  input  logic [COL_W-1:0]   cursor_col_i,
  output logic [VRAM_AW-1:0] vram_addr_o,
  input  logic [7:0]         vram_data_i,
  output logic [CROM_AW-1:0] crom_addr_o,
  input  logic [7:0]         crom_data_i,
  output logic [PX_W-1:0]    px_o,
  output logic               load_o,
  output cell_t              cell_o
);
  logic               running_q;
  logic [PX_W-1:0]    px_q;
  logic [COL_W-1:0]   fcol_q;
  logic [7:0]         code_q;
  logic [7:0]         pat_q;
  logic               fetch_act;
  logic               unused_ma;

  assign fetch_act = fcol_q < cpl_i;
  assign unused_ma = ^ma_i[MA_W-2 -: (MA_W-1-VRAM_AW)];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      px_q      <= '0;
      fcol_q    <= '0;
      code_q    <= '0;
      pat_q     <= '0;
    end else if (line_start_i) begin
      running_q <= 1'b1;
      px_q      <= '0;
      fcol_q    <= '0;
    end else if (running_q) begin
      px_q <= (px_q == PX_W'(CELL_PX-1)) ? '0 : px_q + 1'b1;
      if (px_q == PX_W'(FETCH_PX)) code_q <= vram_data_i;
      if (px_q == PX_W'(PAT_PX))   pat_q  <= crom_data_i;
      if (px_q == PX_W'(CELL_PX-1)) begin
        if (fetch_act) fcol_q    <= fcol_q + 1'b1;
        else           running_q <= 1'b0;
      end
    end
  end

  // index wraps inside the video RAM window
  assign vram_addr_o = ma_i[VRAM_AW-1:0] + VRAM_AW'(fcol_q);
  assign crom_addr_o = {gfx_i, code_q[6:0], ra_i};

  assign px_o   = px_q;
  assign load_o = running_q && (px_q == PX_W'(CELL_PX-1)) && !line_start_i;

  always_comb begin
    cell_o.pat   = pat_q;
    cell_o.rev   = code_q[7];
    cell_o.page  = ma_i[MA_W-1];
    cell_o.cur   = (fcol_q == cursor_col_i);
    cell_o.gfx   = gfx_i;
    cell_o.valid = fetch_act;
  end

  // R3: phase counter never leaves the cell
  a_r3_px_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_q |-> px_q < PX_W'(CELL_PX));

  // R8: strobe restarts at column 0, phase 0
  a_r8_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_start_i |=> (running_q && px_q == '0 && fcol_q == '0));

  // R9: column counter bounded
  a_r9_col_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_q |-> fcol_q <= COL_W'(MAX_COLS));
endmodule

// File: rtl/tps_shifter.sv
`timescale 1ns/1ps
module tps_shifter
  import txt_pix_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clear_i,
  input  logic            load_i,
  input  cell_t           cell_i,
  input  logic [PX_W-1:0] px_i,
  input  logic            disp_en_i,
  output logic            pix_o
);
  cell_t cell_q;
  logic  shift_en;

  // ninth pixel keeps last glyph bit only in graphics mode
  assign shift_en = (px_i < PX_W'(GLYPH_W-1)) ||
                    ((px_i == PX_W'(GLYPH_W-1)) && !cell_q.gfx);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cell_q <= '0;
    end else if (clear_i) begin
      cell_q <= '0;
    end else if (load_i) begin
      cell_q <= cell_i;
    end else if (cell_q.valid && shift_en) begin
      cell_q.pat <= {cell_q.pat[GLYPH_W-2:0], 1'b0};
    end
  end

  assign pix_o = disp_en_i && cell_q.valid &&
                 (cell_q.pat[GLYPH_W-1] ^ cell_q.rev ^ cell_q.page ^ cell_q.cur);

  // R3: a visible cell always begins with a load
  a_r3_load_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (px_i == '0 && cell_q.valid) |-> $past(load_i));

  // R6: graphics mode repeats the eighth bit
  a_r6_gfx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_q.valid && cell_q.gfx && px_i == PX_W'(CELL_PX-1)) |->
      cell_q.pat[GLYPH_W-1] == $past(cell_q.pat[GLYPH_W-1]));

  // R6: text mode ninth bit is blank
  a_r6_text_blank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_q.valid && !cell_q.gfx && px_i == PX_W'(CELL_PX-1)) |->
      !cell_q.pat[GLYPH_W-1]);
endmodule

// File: rtl/txt_pix_serializer.sv
`timescale 1ns/1ps
module txt_pix_serializer
  import txt_pix_pkg::*;
#(
  parameter int MA_W     = 14,
  parameter int RA_W     = 4,
  parameter int VRAM_AW  = 11,
  parameter int MAX_COLS = 128,
  localparam int COL_W   = $clog2(MAX_COLS + 1),
  localparam int CROM_AW = 1 + 7 + RA_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               line_start_i,
  input  logic               disp_en_i,
  input  logic               gfx_mode_i,
  input  logic [MA_W-1:0]    ma_i,
  input  logic [RA_W-1:0]    ra_i,
  input  logic [COL_W-1:0]   chars_per_line_i,
  input  logic [COL_W-1:0]   cursor_col_i,
  output logic [VRAM_AW-1:0] vram_addr_o,
  input  logic [7:0]         vram_data_i,
  output logic [CROM_AW-1:0] crom_addr_o,
  input  logic [7:0]         crom_data_i,
  output logic               pix_o
);
  logic [PX_W-1:0] px;
  logic            load;
  cell_t           next_cell;

  tps_fetch #(
    .MA_W(MA_W), .RA_W(RA_W), .VRAM_AW(VRAM_AW),
    .COL_W(COL_W), .MAX_COLS(MAX_COLS)
  ) u_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .line_start_i (line_start_i),
    .gfx_i        (gfx_mode_i),
    .ma_i         (ma_i),
    .ra_i         (ra_i),
    .cpl_i        (chars_per_line_i),
    .cursor_col_i (cursor_col_i),
    .vram_addr_o  (vram_addr_o),
    .vram_data_i  (vram_data_i),
    .crom_addr_o  (crom_addr_o),
    .crom_data_i  (crom_data_i),
    .px_o         (px),
    .load_o       (load),
    .cell_o       (next_cell)
  );

  tps_shifter u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (line_start_i),
    .load_i    (load),
    .cell_i    (next_cell),
    .px_i      (px),
    .disp_en_i (disp_en_i),
    .pix_o     (pix_o)
  );
endmodule

// File: tb/txt_pix_serializer_bench.sv
`timescale 1ns/1ps
module txt_pix_serializer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0;
  logic        disp_en = 1'b1;
  logic        gfx = 1'b0;
  logic [13:0] ma = '0;
  logic [3:0]  ra = '0;
  logic [7:0]  cpl = '0;
  logic [7:0]  cur = 8'hFF;
  logic [10:0] vram_addr;
  logic [7:0]  vram_q;
  logic [11:0] crom_addr;
  logic [7:0]  crom_q;
  logic        pix;
  int          n_tests = 0;
  int          n_fail  = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] vram_fn(int a);
    return 8'(((a * 29) + (a >> 3)) ^ 'h5A);
  endfunction

  function automatic logic [7:0] crom_fn(int a);
    return 8'(((a * 7) ^ (a >> 5) ^ 'hC3) + (a >> 9));
  endfunction

  always_ff @(posedge clk) begin
    vram_q <= vram_fn(int'(vram_addr));
    crom_q <= crom_fn(int'(crom_addr));
  end

  txt_pix_serializer u_txt_pix_serializer (
    .clk_i            (clk),
    .rst_ni           (rst_n),
    .line_start_i     (line_start),
    .disp_en_i        (disp_en),
    .gfx_mode_i       (gfx),
    .ma_i             (ma),
    .ra_i             (ra),
    .chars_per_line_i (cpl),
    .cursor_col_i     (cur),
    .vram_addr_o      (vram_addr),
    .vram_data_i      (vram_q),
    .crom_addr_o      (crom_addr),
    .crom_data_i      (crom_q),
    .pix_o            (pix)
  );

  function automatic logic exp_pix(int m, int r, bit g, int cc, int c, int n);
    logic [7:0] code, pat;
    int a;
    logic b;
    code = vram_fn((m + c) & 'h7FF);
    a = (int'(g) << 11) | (int'(code[6:0]) << 4) | (r & 'hF);
    pat = crom_fn(a);
    b = (n < 8) ? pat[7-n] : (g ? pat[0] : 1'b0);
    return b ^ code[7] ^ ((m >> 13) & 1) != 0 ^ (c == cc);
  endfunction

  task automatic check(logic got, logic exp, string tag, int c, int n);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s col %0d px %0d: got %b exp %b", tag, c, n, got, exp);
    end
  endtask

  task automatic start_line(int m, int r, bit g, int w, int cc);
    @(negedge clk);
    ma = 14'(m); ra = 4'(r); gfx = g; cpl = 8'(w); cur = 8'(cc);
    disp_en = 1'b1;
    line_start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    line_start = 1'b0;
  endtask

  // starts a line and checks priming, every cell and the blank tail
  task automatic run_line(int m, int r, bit g, int w, int cc, bit de_toggle, string tag);
    logic e, d;
    start_line(m, r, g, w, cc);
    for (int k = 0; k < 9; k++) begin
      if (k > 0) @(negedge clk);
      check(pix, 1'b0, {tag, " R8 prime"}, -1, k);
    end
    for (int c = 0; c < w; c++) begin
      for (int n = 0; n < 9; n++) begin
        @(negedge clk);
        d = de_toggle ? (((c * 9 + n) / 5) % 2 == 0) : 1'b1;
        disp_en = d;
        #1;
        e = d & exp_pix(m, r, g, cc, c, n);
        check(pix, e, tag, c, n);
      end
    end
    disp_en = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      check(pix, 1'b0, {tag, " R9 tail"}, w, k);
    end
  endtask

  task automatic t_reset;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(pix, 1'b0, "R10 reset", -1, k);
    end
  endtask

  task automatic t_text_basic;
    run_line('h0040, 3, 1'b0, 10, 255, 1'b0, "R3 R6 text");
  endtask

  task automatic t_gfx;
    run_line('h0100, 7, 1'b1, 12, 255, 1'b0, "R6 gfx");
  endtask

  task automatic t_page;
    run_line('h2080, 9, 1'b0, 9, 255, 1'b0, "R4 page");
  endtask

  task automatic t_cursor;
    run_line('h0200, 5, 1'b1, 8, 4, 1'b0, "R5 cursor");
    run_line('h0200, 5, 1'b0, 6, 6, 1'b0, "R5 cursor off-line");
  endtask

  task automatic t_wrap;
    run_line('h07FC, 2, 1'b0, 8, 255, 1'b0, "R2 wrap");
  endtask

  task automatic t_bit12;
    run_line('h1010, 11, 1'b1, 6, 255, 1'b0, "R1 bit12");
  endtask

  task automatic t_disp_en;
    run_line('h0300, 1, 1'b1, 10, 2, 1'b1, "R7 enable");
  endtask

  task automatic t_restart;
    start_line('h0500, 4, 1'b0, 20, 255);
    repeat (23) @(negedge clk);
    run_line('h0010, 6, 1'b1, 5, 1, 1'b0, "R8 restart");
  endtask

  task automatic t_widths;
    run_line('h0000, 15, 1'b0, 128, 127, 1'b0, "R9 full");
    run_line('h03FF, 0, 1'b1, 1, 255, 1'b0, "R9 single");
    run_line('h0020, 0, 1'b0, 0, 255, 1'b0, "R9 empty");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_text_basic();
    t_gfx();
    t_page();
    t_cursor();
    t_wrap();
    t_bit12();
    t_disp_en();
    t_restart();
    t_widths();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule